// File: doc/BRIEF.md
# Three-Level PWM Command Qualifier

This block sits between the window comparators on a three-level PWM pin and the gate control of a half-bridge power stage. Two flags reach it: one set while the pin sits above the upper threshold and one set while it sits below the lower threshold. After resynchronising them, the block turns the pin level into one of three commands: drive the high side, drive the low side, or release the high side and let the low side run as an emulated diode. A clean swing between the two outer levels passes with a fixed short latency.

A mid-level reading is accepted only after it has lasted a full qualification window. A mid-level is either a driven mid voltage or a floating pin that the pad current sources pull to the middle. A brief crossing of the middle band during an ordinary edge therefore never releases the high side.

A minimum-width rule keeps very short drive-high or drive-low requests from reaching the bridge. An enable input forces the command to idle. A one-cycle strobe marks every accepted command change.

Top module: `tristate_pwm_qualifier`

## Requirements
- R1: While reset is held, cmd_o reads 2'b00 (idle) and cmd_chg_o reads 0.
- R2: With the block enabled, hi_flag_i=1 with lo_flag_i=0 gives cmd_o=2'b01 (drive high), and lo_flag_i=1 with hi_flag_i=0 gives cmd_o=2'b10 (drive low). Both appear SYNC_STAGES+1 clock edges after the flags change.
- R3: With both flags at 0 (mid band), cmd_o becomes 2'b11 (diode emulation) at the TRI_CYCLES-th consecutive clock edge that samples the synchronised mid band. A mid excursion of fewer samples leaves cmd_o unchanged.
- R4: Both flags at 1 is an illegal code and is qualified exactly like the mid band.
- R5: Any sample outside the mid band restarts the qualification count, so two short mid excursions separated by one outer-level sample never reach 2'b11.
- R6: A change from 2'b01 to 2'b10, or from 2'b10 to 2'b01, happens no sooner than MIN_PULSE cycles after the previous command change. An opposite-level request that ends before then is dropped.
- R7: Leaving 2'b11 or 2'b00 for a driven level is not held back by the minimum-width rule, and neither is entering 2'b11.
- R8: cmd_chg_o is high for exactly the single cycle in which cmd_o takes a new value, and is low in every other cycle.
- R9: With en low, cmd_o becomes 2'b00 at the next edge and stays there, and mid-band qualification does not run. When en rises, cmd_o follows the synchronised pin level at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous enable; low forces idle |
| hi_flag_i | input | 1 | Pin above upper threshold (asynchronous) |
| lo_flag_i | input | 1 | Pin below lower threshold (asynchronous) |
| cmd_o | output | 2 | Command: 00 idle, 01 high, 10 low, 11 diode emulation |
| cmd_chg_o | output | 1 | One-cycle strobe on a command change |

## Verification
The bench uses the default parameters: a two-stage synchroniser, a ten-cycle mid qualification window (50 ns at 200 MHz) and a four-cycle minimum width. With these values the window boundary can be probed directly: a nine-cycle mid excursion is rejected and a ten-cycle one is accepted. The minimum-width rule is exercised by reversing the level within one cycle of a change and by a two-cycle glitch. The three-edge pass-through latency keeps every expected change at a cycle the bench computes exactly.

// File: rtl/tristate_pwm_qualifier_pkg.sv
package tristate_pwm_qualifier_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE = 2'b00,
      CMD_HIGH = 2'b01,
      CMD_LOW  = 2'b10,
      CMD_TRI  = 2'b11
   } bridge_cmd_e;

   typedef enum logic [1:0] {
      LVL_MID  = 2'b00,
      LVL_HIGH = 2'b01,
      LVL_LOW  = 2'b10
   } pin_level_e;

   function automatic pin_level_e decode_level(input logic above, input logic below);
      case ({above, below})
         2'b10:   return LVL_HIGH;
         2'b01:   return LVL_LOW;
         default: return LVL_MID;   // both clear or illegal both set
      endcase
   endfunction
endpackage

// File: rtl/tpq_sync.sv
module tpq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tpq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tpq_mid_timer.sv
module tpq_mid_timer #(
   parameter int TRI_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic is_mid_i,
   output logic accept_o
);
   if (TRI_CYCLES < 2) begin : g_bad_window
      $error("tpq_mid_timer: TRI_CYCLES must be at least 2");
   end

   localparam int CW = $clog2(TRI_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(TRI_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr_i || !is_mid_i) cnt <= '0;
      else if (cnt != LAST)       cnt <= cnt + 1'b1;
   end

   assign accept_o = is_mid_i && !clr_i && (cnt == LAST);

   // R5: acceptance needs the previous sample to have been mid as well
   a_r5_window_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> $past(is_mid_i) && !$past(clr_i));

   // R9: a disabled cycle leaves the count at zero
   a_r9_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !accept_o || cnt == '0);
endmodule

// File: rtl/tristate_pwm_qualifier.sv
module tristate_pwm_qualifier
   import tristate_pwm_qualifier_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TRI_CYCLES  = 10,
   parameter int MIN_PULSE   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       hi_flag_i,
   input  logic       lo_flag_i,
   output logic [1:0] cmd_o,
   output logic       cmd_chg_o
);
   if (MIN_PULSE < 1) begin : g_bad_pulse
      $error("tristate_pwm_qualifier: MIN_PULSE must be at least 1");
   end

   logic [1:0]  flags_s;
   pin_level_e  level;
   logic        tri_ok;
   logic        hold_ok;
   bridge_cmd_e cmd_q, cmd_d;
   logic        chg_q;

   tpq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({hi_flag_i, lo_flag_i}),
      .q_o   (flags_s)
   );

   assign level = decode_level(flags_s[1], flags_s[0]);

   tpq_mid_timer #(.TRI_CYCLES(TRI_CYCLES)) u_mid (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (!en),
      .is_mid_i (level == LVL_MID),
      .accept_o (tri_ok)
   );

   // minimum-width gate: variant chosen by parameter
   if (MIN_PULSE > 1) begin : g_hold
      localparam int HW = $clog2(MIN_PULSE);
      localparam logic [HW-1:0] HOLD_MAX = HW'(MIN_PULSE - 1);
      logic [HW-1:0] age;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              age <= '0;
         else if (cmd_d != cmd_q) age <= '0;
         else if (age != HOLD_MAX) age <= age + 1'b1;
      end

      assign hold_ok = (age == HOLD_MAX);

      // R6: level reversal only after the command has aged MIN_PULSE cycles
      a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
         (($past(cmd_q) == CMD_HIGH && cmd_q == CMD_LOW) ||
          ($past(cmd_q) == CMD_LOW  && cmd_q == CMD_HIGH)) |-> $past(age) == HOLD_MAX);
   end else begin : g_no_hold
      assign hold_ok = 1'b1;
   end

   always_comb begin
      cmd_d = cmd_q;
      if (!en) begin
         cmd_d = CMD_IDLE;
      end else begin
         case (level)
            LVL_HIGH: if (cmd_q != CMD_LOW  || hold_ok) cmd_d = CMD_HIGH;
            LVL_LOW:  if (cmd_q != CMD_HIGH || hold_ok) cmd_d = CMD_LOW;
            default:  if (tri_ok) cmd_d = CMD_TRI;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= CMD_IDLE;
         chg_q <= 1'b0;
      end else begin
         cmd_q <= cmd_d;
         chg_q <= (cmd_d != cmd_q);
      end
   end

   assign cmd_o     = cmd_q;
   assign cmd_chg_o = chg_q;

   // R8: strobe and command change coincide
   a_r8_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_chg_o |-> cmd_o != $past(cmd_o));
   a_r8_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o != $past(cmd_o) |-> cmd_chg_o);

   // R9: disabled means idle on the next edge
   a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cmd_o == CMD_IDLE);

   // R3: diode emulation is entered only from a qualified mid sample
   a_r3_tri_from_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_TRI && $past(cmd_o) != CMD_TRI) |-> $past(level) == LVL_MID && $past(en));

   // R7: once enabled and active, the command never falls back to idle
   a_r7_no_idle_while_on: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmd_o != CMD_IDLE) |=> (cmd_o != CMD_IDLE) || !$past(en));
endmodule

// File: tb/tristate_pwm_qualifier_bench.sv
module tristate_pwm_qualifier_bench;
   localparam logic [1:0] IDLE = 2'b00, HIGH = 2'b01, LOW = 2'b10, TRI = 2'b11;
   localparam int TRI_N = 10;

   logic clk = 1'b0;
   logic rst_n, en, hi, lo;
   logic [1:0] cmd;
   logic chg;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   int         q_cyc[$];
   logic [1:0] q_cmd[$];
   string      q_req[$];

   always #2.5 clk = ~clk;   // 200 MHz
   always @(posedge clk) cyc <= cyc + 1;

   tristate_pwm_qualifier u_tristate_pwm_qualifier (
      .clk(clk), .rst_n(rst_n), .en(en),
      .hi_flag_i(hi), .lo_flag_i(lo),
      .cmd_o(cmd), .cmd_chg_o(chg)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic expect_at(input int at, input logic [1:0] c, input string req);
      q_cyc.push_back(at);
      q_cmd.push_back(c);
      q_req.push_back(req);
   endtask

   task automatic pin(input logic h, input logic l);
      hi = h; lo = l;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected changes as strobes appear
   logic [1:0] prev_cmd = 2'b00;
   always @(negedge clk) begin
      if (mon_on) begin
         if ((cmd != prev_cmd) != chg)
            chk(1'b0, "R8 strobe/change mismatch", int'(chg), int'(cmd != prev_cmd));
         if (chg) begin
            if (q_cyc.size() == 0) begin
               chk(1'b0, "R8 unexpected change", int'(cmd), int'(prev_cmd));
            end else begin
               chk(q_cyc[0] == cyc, {q_req[0], " change cycle"}, cyc, q_cyc[0]);
               chk(q_cmd[0] == cmd, {q_req[0], " command value"}, int'(cmd), int'(q_cmd[0]));
               void'(q_cyc.pop_front());
               void'(q_cmd.pop_front());
               void'(q_req.pop_front());
            end
         end
      end
      prev_cmd = cmd;
   end

   initial begin
      int c;
      rst_n = 1'b0; en = 1'b0; pin(1'b1, 1'b0);
      wait_n(3);
      chk(cmd == IDLE && chg == 1'b0, "R1 reset state", int'({cmd, chg}), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      wait_n(4);

      // R9: enabling with pin high follows at next edge
      c = cyc; en = 1'b1; expect_at(c + 1, HIGH, "R9 enable");
      wait_n(8);
      // R2: clean low and high pass with three-edge latency
      c = cyc; pin(1'b0, 1'b1); expect_at(c + 3, LOW, "R2 to low");
      wait_n(8);
      c = cyc; pin(1'b1, 1'b0); expect_at(c + 3, HIGH, "R2 to high");
      wait_n(8);
      // R3: nine mid cycles rejected
      pin(1'b0, 1'b0); wait_n(TRI_N - 1); pin(1'b1, 1'b0); wait_n(8);
      chk(cmd == HIGH, "R3 short mid ignored", int'(cmd), int'(HIGH));
      // R3: ten mid cycles accepted
      c = cyc; pin(1'b0, 1'b0); expect_at(c + 2 + TRI_N, TRI, "R3 mid accepted");
      wait_n(14);
      // R7: leaving diode emulation is immediate
      c = cyc; pin(1'b0, 1'b1); expect_at(c + 3, LOW, "R7 exit tri");
      wait_n(8);
      // R4: illegal code qualifies as mid
      c = cyc; pin(1'b1, 1'b1); expect_at(c + 2 + TRI_N, TRI, "R4 illegal as mid");
      wait_n(14);
      // R6: reversal deferred until the command is MIN_PULSE old
      c = cyc; pin(1'b1, 1'b0); expect_at(c + 3, HIGH, "R7 tri to high");
      wait_n(1); pin(1'b0, 1'b1); expect_at(c + 7, LOW, "R6 deferred reversal");
      wait_n(10);
      // R6: two-cycle glitch right after a change is dropped
      c = cyc; pin(1'b1, 1'b0); expect_at(c + 3, HIGH, "R2 high again");
      wait_n(1); pin(1'b0, 1'b1); wait_n(2); pin(1'b1, 1'b0);
      wait_n(10);
      chk(cmd == HIGH, "R6 glitch dropped", int'(cmd), int'(HIGH));
      // R5: mid, one high sample, mid never qualifies
      pin(1'b0, 1'b0); wait_n(6); pin(1'b1, 1'b0); wait_n(1);
      pin(1'b0, 1'b0); wait_n(6); pin(1'b1, 1'b0); wait_n(8);
      chk(cmd == HIGH, "R5 count restarts", int'(cmd), int'(HIGH));
      // R9: disable, no qualification while off, re-enable to low
      c = cyc; en = 1'b0; expect_at(c + 1, IDLE, "R9 disable");
      wait_n(3);
      pin(1'b0, 1'b0); wait_n(15);
      chk(cmd == IDLE, "R9 held idle", int'(cmd), int'(IDLE));
      pin(1'b0, 1'b1); wait_n(4);
      c = cyc; en = 1'b1; expect_at(c + 1, LOW, "R9 re-enable");
      wait_n(6);
      chk(q_cyc.size() == 0, "R8 all expected changes seen", q_cyc.size(), 0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule